// File: doc/BRIEF.md
# MMU Control Register and Flush Controller

This block sits on the alternate-space access path of a 32-bit memory management unit. A single access strobe carries a read/write flag, a space identifier, a 32-bit address and write data. When the space identifier selects the register space, address bits [11:8] pick one of sixteen 32-bit control registers. When it selects the flush/probe space, the same bits carry a level: stores become translation-cache flush requests, and loads become probe requests. Probe requests are forwarded to an external table-walk port, or answered with zero when the level is out of range.

Several registers have side effects. The fault status register clears itself once it has been read. The control register keeps only an enable bit and a no-fault bit. Changing those bits, or changing the context register, requests a full flush. The fault status and fault address registers cannot be written by software. They are loaded by a hardware fault-capture input. Read data and flush requests are registered and appear in the cycle after the strobe.

Top module: `mmu_regctl`

## Requirements
- R1: In the register space (identifier 4), address bits [11:8] select the register for both loads and stores. A load places the selected value on `rd_data` in the cycle after the strobe. `rd_data` holds its value until the next load.
- R2: A load of register 3 (fault status) returns its current value and clears the register to zero. If a fault capture occurs in the same cycle, the captured value is kept instead of the clear.
- R3: A store to register 0 keeps only bit 0 (enable) and bit 1 (no-fault). All other bits read back as zero. If either kept bit changes, a full flush is requested.
- R4: A store to register 2 (context) keeps the whole word. A full flush is requested only if the stored value differs from the old one.
- R5: Stores to registers 3 and 4 have no effect. Stores to any other index except 0 and 2 keep the whole word and request no flush.
- R6: A store in the flush/probe space (identifier 3) with level (bits [11:8]) 0 requests a page flush. The page address is the access address with bits [11:0] cleared.
- R7: A flush/probe-space store with level 1 to 4 requests a full flush. A store with level 5 to 15 requests nothing.
- R8: A flush/probe-space load with level 0 to 4 raises `probe_req` in the same cycle and returns `probe_rdata` on `rd_data`. A load with a level above 4 returns zero and raises no probe.
- R9: An access with any other space identifier returns zero on a load. On a store it changes no register and requests no flush.
- R10: `pflush_req` and `fflush_req` are single-cycle pulses in the cycle after the store strobe. They are never both high.
- R11: After reset, all registers and all outputs are zero.
- R12: When `flt_wr` is high, register 3 takes `flt_status` and register 4 takes `flt_addr` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_space | input | 8 | Space identifier |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Store data |
| rd_data | output | 32 | Load result, valid the cycle after a load |
| probe_req | output | 1 | Probe forwarded to the table walker (same cycle) |
| probe_addr | output | 32 | Probe address |
| probe_level | output | 4 | Probe level |
| probe_rdata | input | 32 | Probe answer, sampled in the probe cycle |
| flt_wr | input | 1 | Fault capture strobe |
| flt_status | input | 32 | Captured fault status |
| flt_addr | input | 32 | Captured fault address |
| pflush_req | output | 1 | Page flush pulse |
| pflush_addr | output | 32 | Page-aligned flush address |
| fflush_req | output | 1 | Full flush pulse |

## Verification
The bench targets the change-only flush rules. It rewrites register 0 with the same enable and no-fault bits, but with different upper bits, and it rewrites the context with an unchanged value. A design that flushes on every store would pulse `fflush_req` there. The bench reads the fault status twice, and also reads it in the same cycle as a fault capture. A design that clears the register late, or lets the clear beat the capture, would lose or leak the status. The bench sweeps all sixteen levels in both flush and probe form. An off-by-one level limit would flush or probe at level 5, or miss level 4. The bench also shows that stores to the read-only slots and to unknown spaces leave the registers unchanged.

// File: rtl/mmu_regctl.sv
module mmu_regctl #(
  parameter int DW          = 32,
  parameter int AW          = 32,
  parameter int SPACE_W     = 8,
  parameter int IDX_LSB     = 8,
  parameter int IDX_W       = 4,
  parameter int PAGE_BITS   = 12,
  parameter int MAX_LEVEL   = 4,
  parameter int SPACE_FLUSH = 3,
  parameter int SPACE_REGS  = 4,
  parameter int CTRL_REG    = 0,
  parameter int CTX_REG     = 2,
  parameter int FSTAT_REG   = 3,
  parameter int FADDR_REG   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_vld,
  input  logic               acc_wr,
  input  logic [SPACE_W-1:0] acc_space,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  output logic [DW-1:0]      rd_data,
  output logic               probe_req,
  output logic [AW-1:0]      probe_addr,
  output logic [IDX_W-1:0]   probe_level,
  input  logic [DW-1:0]      probe_rdata,
  input  logic               flt_wr,
  input  logic [DW-1:0]      flt_status,
  input  logic [DW-1:0]      flt_addr,
  output logic               pflush_req,
  output logic [AW-1:0]      pflush_addr,
  output logic               fflush_req
);

  localparam int NREG = 1 << IDX_W;
  localparam logic [DW-1:0] CTRL_MASK = DW'(3);

  logic [DW-1:0]    regs [NREG];
  logic [IDX_W-1:0] idx;
  logic             is_reg, is_fp, ld_reg, st_reg, lvl_ok;
  logic             ctrl_chg, ctx_chg, pf_hit, ff_hit;
  logic [DW-1:0]    rd_next;

  assign idx    = acc_addr[IDX_LSB +: IDX_W];
  assign is_reg = acc_vld && (acc_space == SPACE_W'(SPACE_REGS));
  assign is_fp  = acc_vld && (acc_space == SPACE_W'(SPACE_FLUSH));
  assign ld_reg = is_reg && !acc_wr;
  assign st_reg = is_reg && acc_wr;
  assign lvl_ok = idx <= IDX_W'(MAX_LEVEL);

  assign ctrl_chg = st_reg && (idx == IDX_W'(CTRL_REG)) &&
                    ((acc_wdata & CTRL_MASK) != regs[CTRL_REG]);
  assign ctx_chg  = st_reg && (idx == IDX_W'(CTX_REG)) &&
                    (acc_wdata != regs[CTX_REG]);
  assign pf_hit   = is_fp && acc_wr && (idx == '0);
  assign ff_hit   = ctrl_chg || ctx_chg || (is_fp && acc_wr && (idx != '0) && lvl_ok);

  assign probe_req   = is_fp && !acc_wr && lvl_ok;
  assign probe_addr  = acc_addr;
  assign probe_level = idx;

  assign rd_next = ld_reg    ? regs[idx] :
                   probe_req ? probe_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= '0;
      pflush_req  <= 1'b0;
      pflush_addr <= '0;
      fflush_req  <= 1'b0;
    end else begin
      if (acc_vld && !acc_wr) rd_data <= rd_next;
      pflush_req <= pf_hit;
      fflush_req <= ff_hit;
      if (pf_hit) pflush_addr <= {acc_addr[AW-1:PAGE_BITS], PAGE_BITS'(0)};
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel;
    assign sel = (idx == IDX_W'(g));
    if (g == FSTAT_REG) begin : g_fstat
      always_ff @(posedge clk) begin
        if (!rst_n)              regs[g] <= '0;
        else if (flt_wr)         regs[g] <= flt_status;
        else if (ld_reg && sel)  regs[g] <= '0;
      end
    end else if (g == FADDR_REG) begin : g_faddr
      always_ff @(posedge clk) begin
        if (!rst_n)      regs[g] <= '0;
        else if (flt_wr) regs[g] <= flt_addr;
      end
    end else if (g == CTRL_REG) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n)              regs[g] <= '0;
        else if (st_reg && sel)  regs[g] <= acc_wdata & CTRL_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)              regs[g] <= '0;
        else if (st_reg && sel)  regs[g] <= acc_wdata;
      end
    end
  end

  AST_PF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pflush_req |-> pflush_addr[PAGE_BITS-1:0] == '0); // R6
  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pflush_req && fflush_req)); // R10
  AST_FSTAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_reg && idx == IDX_W'(FSTAT_REG) && !flt_wr) |=> regs[FSTAT_REG] == '0); // R2
  AST_CTRL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_reg && idx == IDX_W'(CTRL_REG)) |=>
      regs[CTRL_REG] == ($past(acc_wdata) & CTRL_MASK)); // R3
  AST_FADDR_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_reg && idx == IDX_W'(FADDR_REG) && !flt_wr) |=> $stable(regs[FADDR_REG])); // R5
  AST_PROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fp && !acc_wr && !lvl_ok) |=> rd_data == '0); // R8
  AST_FLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (fflush_req || pflush_req) |-> $past(acc_vld && acc_wr)); // R10

endmodule

// File: tb/mmu_regctl_tb.sv
module mmu_regctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0, acc_wr = 1'b0, flt_wr = 1'b0;
  logic [7:0]  acc_space = '0;
  logic [31:0] acc_addr = '0, acc_wdata = '0, flt_status = '0, flt_addr = '0;
  logic [31:0] rd_data, probe_addr, probe_rdata, pflush_addr;
  logic [3:0]  probe_level;
  logic        probe_req, pflush_req, fflush_req;

  always #4 clk = ~clk;

  assign probe_rdata = 32'hC0DE0000 | {16'h0, acc_addr[15:0]};

  mmu_regctl dut_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .probe_req(probe_req), .probe_addr(probe_addr),
    .probe_level(probe_level), .probe_rdata(probe_rdata), .flt_wr(flt_wr),
    .flt_status(flt_status), .flt_addr(flt_addr), .pflush_req(pflush_req),
    .pflush_addr(pflush_addr), .fflush_req(fflush_req)
  );

  int unsigned mr [16];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_rd = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit vld, bit wr, logic [7:0] sp,
                      logic [31:0] addr, logic [31:0] wd,
                      bit fw = 0, logic [31:0] fs = 0, logic [31:0] fa = 0);
    int lvl;
    bit pf, ff, pr;
    logic [31:0] pfa;
    acc_vld = vld; acc_wr = wr; acc_space = sp; acc_addr = addr; acc_wdata = wd;
    flt_wr = fw; flt_status = fs; flt_addr = fa;
    #1;
    lvl = int'(addr[11:8]);
    pr = vld && !wr && sp == 8'd3 && lvl <= 4;
    chk({tag, " probe_req"}, {31'b0, probe_req}, {31'b0, pr});
    if (pr) chk({tag, " probe_addr"}, probe_addr, addr);
    pf = 0; ff = 0; pfa = '0;
    if (vld && wr && sp == 8'd3) begin
      if (lvl == 0) begin pf = 1; pfa = addr & 32'hFFFF_F000; end
      else if (lvl <= 4) ff = 1;
    end
    if (vld && !wr)
      exp_rd = (sp == 8'd4) ? mr[lvl] : pr ? (32'hC0DE0000 | {16'h0, addr[15:0]}) : 32'h0;
    if (vld && wr && sp == 8'd4) begin
      case (lvl)
        0: begin if ((wd & 32'h3) != mr[0]) ff = 1; mr[0] = wd & 32'h3; end
        2: begin if (wd != mr[2]) ff = 1; mr[2] = wd; end
        3, 4: ;
        default: mr[lvl] = wd;
      endcase
    end
    if (vld && !wr && sp == 8'd4 && lvl == 3) mr[3] = 0;
    if (fw) begin mr[3] = fs; mr[4] = fa; end
    @(posedge clk);
    @(negedge clk);
    acc_vld = 0; acc_wr = 0; flt_wr = 0;
    chk({tag, " rd_data"}, rd_data, exp_rd);
    chk({tag, " pflush_req"}, {31'b0, pflush_req}, {31'b0, pf});
    chk({tag, " fflush_req"}, {31'b0, fflush_req}, {31'b0, ff});
    if (pf) chk({tag, " pflush_addr"}, pflush_addr, pfa);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 8'h0, 32'h0, 32'h0);
  endtask

  task automatic rd(string tag, int r);
    step(tag, 1, 0, 8'd4, 32'(r) << 8, 32'h0);
  endtask

  task automatic wr(string tag, int r, logic [31:0] d);
    step(tag, 1, 1, 8'd4, 32'(r) << 8, d);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mr[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R11 rd_data reset", rd_data, 32'h0);
    chk("R11 pflush reset", {31'b0, pflush_req}, 32'h0);
    chk("R11 fflush reset", {31'b0, fflush_req}, 32'h0);
    for (int i = 0; i < 16; i++) rd("R11 reg reset", i);

    wr("R5 plain store", 5, 32'h1234_5678);
    rd("R1 read back", 5);
    idle("R1 rd_data holds");
    wr("R5 plain store 15", 15, 32'hDEAD_BEEF);
    rd("R1 read idx 15", 15);

    wr("R3 ctrl set", 0, 32'hFFFF_FFFF);
    idle("R10 pulse ends");
    wr("R3 ctrl same bits", 0, 32'hFFFF_FFF3);
    wr("R3 ctrl change", 0, 32'h0000_0001);
    rd("R3 ctrl read", 0);

    wr("R4 ctx change", 2, 32'h0000_0055);
    wr("R4 ctx same", 2, 32'h0000_0055);
    rd("R4 ctx read", 2);

    step("R12 fault capture", 0, 0, 8'h0, 32'h0, 32'h0, 1, 32'h0000_0A5C, 32'h8000_1234);
    rd("R12 fault addr", 4);
    rd("R2 fstat first read", 3);
    rd("R2 fstat cleared", 3);
    step("R12 fault again", 0, 0, 8'h0, 32'h0, 32'h0, 1, 32'h0000_0777, 32'h4000_0000);
    wr("R5 fstat ignored", 3, 32'hFFFF_FFFF);
    wr("R5 faddr ignored", 4, 32'hFFFF_FFFF);
    rd("R5 fstat unchanged", 3);
    rd("R5 faddr unchanged", 4);
    step("R2 read with capture", 1, 0, 8'd4, 32'h0000_0300, 32'h0, 1, 32'h0000_0999, 32'h1);
    rd("R2 capture wins", 3);

    step("R6 page flush", 1, 1, 8'd3, 32'h1234_50FF, 32'h0);
    idle("R10 page pulse ends");
    for (int l = 0; l < 16; l++) begin
      step("R7 flush level", 1, 1, 8'd3, 32'hABCD_0000 | (32'(l) << 8) | 32'h3C, 32'h0);
      idle("R10 after flush level");
    end
    for (int l = 0; l < 16; l++)
      step("R8 probe level", 1, 0, 8'd3, 32'h5550_0000 | (32'(l) << 8) | 32'(l), 32'h0);

    step("R9 unknown store", 1, 1, 8'h20, 32'h0000_0500, 32'hFFFF_0000);
    rd("R9 reg unchanged", 5);
    step("R9 unknown load", 1, 0, 8'h45, 32'h0000_0500, 32'h0);
    step("R9 unknown store ctx", 1, 1, 8'h00, 32'h0000_0200, 32'h0000_0099);
    rd("R9 ctx unchanged", 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule